// File: doc/BRIEF.md
# Bridge Read Prefetch Cache

This block is the downstream read engine of a bus bridge. A legacy bus master issues word reads, one address per cycle, toward memory that sits on the far (upstream) side of the bridge. When a read finds no usable buffered data, the block answers the master with retry. It remembers the address and sends one upstream read whose length is programmed in cache lines. Returned words fill an internal buffer. The master, which keeps retrying, is then served word by word as the data lands.

Masters of this kind often take one or two lines and then end the transfer. With the short-term cache enabled, the words left over stay valid after that disconnect. A later read that continues at the next unread address is served at once, with no retry and no new upstream traffic. A programmable hold timer throws the leftovers away once they have sat idle too long. With the cache disabled, every disconnect empties the buffer.

Top module: `rd_prefetch_cache`

## Requirements
- R1: A read that cannot be served is answered with `rspRetry`. If no upstream fetch is outstanding and the address is not the buffer's next unread address, the block issues exactly one upstream read. That read starts at the requested address and carries the current prefetch length in `upReqWords`.
- R2: The prefetch length in 32-bit words is `cfgLines` times the line size divided by 4. `cfgLineSel` codes 0, 1, 2 and 3 select 16, 32, 64 and 128 byte lines. A `cfgLines` of 0 counts as 1, and the result is capped at DEPTH (64) words.
- R3: A read hits when its address equals the next unread buffer address and that word has arrived. A hit gives `rspAck` in the same cycle, and `rspData` equals the upstream word for that address. The next unread address then advances by 4.
- R4: A read at the next unread address whose word has not yet arrived gets retry and causes no extra upstream read.
- R5: With `cfgCacheEn`=1, an acknowledged read with `reqLast`=1 (master disconnect) keeps the unread words. A following read at the next address hits with no retry and no upstream read.
- R6: With `cfgCacheEn`=0, a master disconnect discards the buffer. The next read retries and is fetched again.
- R7: A read at any address other than the next unread address invalidates the buffer. It is then served by a new upstream read.
- R8: The hold timer restarts at each disconnect. After `cfgHold` cycles with valid data, no request and no outstanding fetch, the buffer is invalidated. A `cfgHold` of 0 holds the data without limit.
- R9: The hold timer does not advance while an upstream fetch is outstanding.
- R10: When the last prefetched word is acknowledged, `rspStop` is raised in that cycle and the buffer becomes empty, even if `reqLast` is 0.
- R11: After reset no response and no upstream request is active. `upReqValid` and `upReqAddr` hold steady until `upReqReady` is seen.
- R12: Every cycle with `reqValid` gets exactly one of `rspAck` or `rspRetry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCacheEn | input | 1 | Keep leftover words after disconnect |
| cfgLineSel | input | 2 | Line size code: 16/32/64/128 bytes |
| cfgLines | input | 4 | Prefetch length in lines (0 means 1) |
| cfgHold | input | 16 | Idle cycles leftover data is held (0 = unlimited) |
| reqValid | input | 1 | Master presents a word read this cycle |
| reqAddr | input | 32 | Byte address of the word |
| reqLast | input | 1 | Master ends the transfer after this word |
| rspAck | output | 1 | Word delivered this cycle |
| rspRetry | output | 1 | Master must retry this read |
| rspStop | output | 1 | Block ends the transfer: buffer drained |
| rspData | output | 32 | Read data, valid with rspAck |
| upReqValid | output | 1 | Upstream read request |
| upReqAddr | output | 32 | Upstream start address |
| upReqWords | output | 7 | Upstream length in words |
| upReqReady | input | 1 | Upstream accepts the request |
| upRspValid | input | 1 | One returned word this cycle |
| upRspData | input | 32 | Returned word, in address order |

## Verification
The bench goes after the boundary between served and refetched reads. It counts retries and upstream fetches for repeated short sequential reads with the cache on and off. A block that discarded leftovers regardless of the enable would show a fetch where none is due, and one that kept them when disabled would show none where one is due. The hold window is probed on both sides. One case idles longer than the hold limit and expects a refetch. Another idles briefly while the fetch is still streaming and expects a hit, which catches a timer that ticks during a fetch. Over-long bursts at several line sizes, including the 64-word cap, expect `rspStop` on exactly the last prefetched word. A wrong length computation or a missing cap moves that stop or corrupts data. A jump to an unrelated address must force a refetch, so a block that compared addresses loosely would return stale words.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  // Per-cycle commands from the control unit to the datapath
  typedef struct packed {
    logic loadBase;   // start a new prefetch window at reqAddr
    logic fillWrite;  // store one returned upstream word
    logic consume;    // master took the head word
  } rpcStrobes_t;
endpackage

// File: rtl/rpc_datapath.sv
module rpc_datapath
  import rpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64,
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rpcStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] upRspData,
  input  logic [LEN_W-1:0]  fetchLen,
  output logic              addrMatch,
  output logic              headReady,
  output logic              drainDone,
  output logic              fillDone,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] upReqAddr,
  output logic [LEN_W-1:0]  upReqWords
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] baseAddr;
  logic [LEN_W-1:0]  headCnt;
  logic [LEN_W-1:0]  fillCnt;
  logic [LEN_W-1:0]  lenHeld;

  always_ff @(posedge clk) begin
    if (strobes.fillWrite) store[fillCnt[IDX_W-1:0]] <= upRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      baseAddr <= '0;
      headCnt  <= '0;
      fillCnt  <= '0;
      lenHeld  <= '0;
    end else if (strobes.loadBase) begin
      nextAddr <= reqAddr;
      baseAddr <= reqAddr;
      headCnt  <= '0;
      fillCnt  <= '0;
      lenHeld  <= fetchLen;
    end else begin
      if (strobes.fillWrite) fillCnt <= fillCnt + LEN_W'(1);
      if (strobes.consume) begin
        headCnt  <= headCnt + LEN_W'(1);
        nextAddr <= nextAddr + WORD_STEP;
      end
    end
  end

  assign addrMatch  = (reqAddr == nextAddr);
  assign headReady  = (headCnt < fillCnt);
  assign drainDone  = ((headCnt + LEN_W'(1)) == lenHeld);
  assign fillDone   = ((fillCnt + LEN_W'(1)) == lenHeld);
  assign rdData     = store[headCnt[IDX_W-1:0]];
  assign upReqAddr  = baseAddr;
  assign upReqWords = lenHeld;
endmodule

// File: rtl/rpc_ctrl.sv
module rpc_ctrl
  import rpc_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int HOLD_W  = 16,
  parameter int LINES_W = 4,
  parameter int LEN_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgCacheEn,
  input  logic [1:0]         cfgLineSel,
  input  logic [LINES_W-1:0] cfgLines,
  input  logic [HOLD_W-1:0]  cfgHold,
  input  logic               reqValid,
  input  logic               reqLast,
  input  logic               addrMatch,
  input  logic               headReady,
  input  logic               drainDone,
  input  logic               fillDone,
  input  logic               upReqReady,
  input  logic               upRspValid,
  output rpcStrobes_t        strobes,
  output logic [LEN_W-1:0]   fetchLen,
  output logic               rspAck,
  output logic               rspRetry,
  output logic               rspStop,
  output logic               upReqValid
);
  // 128-byte lines are 32 words: shift by up to 5
  localparam int RAW_W = LINES_W + 6;

  logic              bufValid;
  logic              busy;
  logic              reqPend;
  logic [HOLD_W-1:0] age;

  logic [LINES_W-1:0] linesEff;
  logic [RAW_W-1:0]   rawWords;
  logic               hit, disconnect, staleReq, fetchStart;
  logic               idleTick, expire, dropBuf;
  logic [HOLD_W-1:0]  nextAge;

  // Prefetch length in words, capped at the buffer depth
  always_comb begin
    linesEff = (cfgLines == '0) ? LINES_W'(1) : cfgLines;
    rawWords = RAW_W'(linesEff) << ({1'b0, cfgLineSel} + 3'd2);
    fetchLen = (rawWords > RAW_W'(DEPTH)) ? LEN_W'(DEPTH) : LEN_W'(rawWords);
  end

  always_comb begin
    hit        = bufValid && addrMatch && headReady;
    rspAck     = reqValid && hit;
    rspRetry   = reqValid && !hit;
    rspStop    = rspAck && drainDone;
    disconnect = rspAck && (reqLast || drainDone);
    staleReq   = rspRetry && bufValid && !addrMatch;
    fetchStart = rspRetry && !busy && !(bufValid && addrMatch);
    idleTick   = bufValid && !busy && !reqValid;
    nextAge    = age + HOLD_W'(1);
    expire     = idleTick && (cfgHold != '0) && (nextAge == cfgHold);
    dropBuf    = (disconnect && (drainDone || !cfgCacheEn)) || staleReq || expire;

    strobes.loadBase  = fetchStart;
    strobes.fillWrite = busy && upRspValid;
    strobes.consume   = rspAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      busy     <= 1'b0;
      reqPend  <= 1'b0;
      age      <= '0;
    end else begin
      if (fetchStart)   bufValid <= 1'b1;
      else if (dropBuf) bufValid <= 1'b0;

      if (fetchStart)                          busy <= 1'b1;
      else if (strobes.fillWrite && fillDone)  busy <= 1'b0;

      if (fetchStart)      reqPend <= 1'b1;
      else if (upReqReady) reqPend <= 1'b0;

      if (fetchStart || disconnect) age <= '0;
      else if (idleTick)            age <= nextAge;
    end
  end

  assign upReqValid = reqPend;
endmodule

// File: rtl/rd_prefetch_cache.sv
module rd_prefetch_cache
  import rpc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 64,
  parameter int HOLD_W  = 16,
  parameter int LINES_W = 4,
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgCacheEn,
  input  logic [1:0]         cfgLineSel,
  input  logic [LINES_W-1:0] cfgLines,
  input  logic [HOLD_W-1:0]  cfgHold,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqLast,
  output logic               rspAck,
  output logic               rspRetry,
  output logic               rspStop,
  output logic [DATA_W-1:0]  rspData,
  output logic               upReqValid,
  output logic [ADDR_W-1:0]  upReqAddr,
  output logic [LEN_W-1:0]   upReqWords,
  input  logic               upReqReady,
  input  logic               upRspValid,
  input  logic [DATA_W-1:0]  upRspData
);
  rpcStrobes_t       strobes;
  logic [LEN_W-1:0]  fetchLen;
  logic              addrMatch, headReady, drainDone, fillDone;
  logic [DATA_W-1:0] rdData;

  rpc_ctrl #(
    .DEPTH(DEPTH), .HOLD_W(HOLD_W), .LINES_W(LINES_W), .LEN_W(LEN_W)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .cfgCacheEn(cfgCacheEn), .cfgLineSel(cfgLineSel),
    .cfgLines(cfgLines), .cfgHold(cfgHold),
    .reqValid(reqValid), .reqLast(reqLast),
    .addrMatch(addrMatch), .headReady(headReady),
    .drainDone(drainDone), .fillDone(fillDone),
    .upReqReady(upReqReady), .upRspValid(upRspValid),
    .strobes(strobes), .fetchLen(fetchLen),
    .rspAck(rspAck), .rspRetry(rspRetry), .rspStop(rspStop),
    .upReqValid(upReqValid)
  );

  rpc_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .LEN_W(LEN_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .upRspData(upRspData), .fetchLen(fetchLen),
    .addrMatch(addrMatch), .headReady(headReady),
    .drainDone(drainDone), .fillDone(fillDone),
    .rdData(rdData), .upReqAddr(upReqAddr), .upReqWords(upReqWords)
  );

  assign rspData = rspAck ? rdData : '0;
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgCacheEn,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqLast,
  input logic              rspAck,
  input logic              rspRetry,
  input logic              rspStop,
  input logic              upReqValid,
  input logic              upReqReady,
  input logic [ADDR_W-1:0] upReqAddr
);
  assert_one_answer_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(rspAck && rspRetry));

  assert_answered_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (rspAck || rspRetry));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (upReqValid && !upReqReady) |=> (upReqValid && $stable(upReqAddr)));

  assert_fetch_after_retry_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upReqValid) |-> $past(rspRetry));

  assert_seq_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspAck |=> (rspAck |-> (reqAddr == $past(reqAddr) + ADDR_W'(4))));

  assert_stop_is_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspStop |-> rspAck);

  assert_empty_after_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspStop |=> (reqValid |-> rspRetry));

  assert_discard_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgCacheEn && rspAck && reqLast) |=> (reqValid |-> !rspAck));
endmodule

bind rd_prefetch_cache rpc_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .cfgCacheEn(cfgCacheEn),
  .reqValid(reqValid), .reqAddr(reqAddr), .reqLast(reqLast),
  .rspAck(rspAck), .rspRetry(rspRetry), .rspStop(rspStop),
  .upReqValid(upReqValid), .upReqReady(upReqReady), .upReqAddr(upReqAddr)
);

// File: tb/rd_prefetch_cache_test.sv
module rd_prefetch_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int UP_LAT     = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgCacheEn = 1'b1;
  logic [1:0]  cfgLineSel = 2'd0;
  logic [3:0]  cfgLines = 4'd4;
  logic [15:0] cfgHold = 16'd1000;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqLast = 1'b0;
  logic        rspAck, rspRetry, rspStop;
  logic [31:0] rspData;
  logic        upReqValid;
  logic [31:0] upReqAddr;
  logic [6:0]  upReqWords;
  logic        upReqReady = 1'b1;
  logic        upRspValid = 1'b0;
  logic [31:0] upRspData = '0;

  rd_prefetch_cache uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int fetchCount = 0;
  int retries, acks, stopSeen;
  logic [31:0] lastUpAddr = '0;
  int lastUpWords = 0;
  int stallReq = 0;
  logic [31:0] expQ[$];

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C3C_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Upstream memory model: accepts a request, returns words after UP_LAT
  int upLeft = 0;
  int upWait = 0;
  logic [31:0] upPtr = '0;
  int stallLeft = 0;
  always @(negedge clk) begin
    upRspValid = 1'b0;
    if (upLeft > 0) begin
      if (upWait > 0) upWait--;
      else begin
        upRspValid = 1'b1;
        upRspData  = memWord(upPtr);
        upPtr      = upPtr + 32'd4;
        upLeft--;
      end
    end
    if (upReqValid) begin
      if (upReqReady && stallLeft == 0 && stallReq > 0) begin
        stallLeft = stallReq;
        stallReq  = 0;
      end
      if (stallLeft > 0) begin
        upReqReady = 1'b0;
        stallLeft--;
      end else begin
        upReqReady  = 1'b1;
        lastUpAddr  = upReqAddr;
        lastUpWords = int'(upReqWords);
        upPtr       = upReqAddr;
        upLeft      = int'(upReqWords);
        upWait      = UP_LAT;
      end
    end else begin
      upReqReady = 1'b1;
    end
  end

  // Monitor: scoreboard compare of delivered words, fetch counting
  always @(negedge clk) begin
    #2;
    if (rstN && reqValid && rspAck) begin
      logic [31:0] exp;
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected data actual=%0h expected=none", rspData);
      end else begin
        exp = expQ.pop_front();
        if (rspData !== exp) begin
          bad++;
          $display("FAIL R3 data actual=%0h expected=%0h", rspData, exp);
        end
      end
    end
    if (rstN && upReqValid && upReqReady) fetchCount++;
  end

  // Driver: one master transfer of up to n words from address a
  task automatic readBurst(input logic [31:0] a, input int n);
    retries = 0; acks = 0; stopSeen = 0;
    for (int i = 0; i < n; i++) begin
      expQ.push_back(memWord(a + 32'(4 * i)));
      forever begin
        @(negedge clk);
        reqValid = 1'b1;
        reqAddr  = a + 32'(4 * i);
        reqLast  = (i == n - 1);
        #1;
        if (rspAck) begin
          acks++;
          if (rspStop) stopSeen = 1;
          break;
        end
        retries++;
      end
      if (stopSeen != 0) break;
    end
    @(negedge clk);
    reqValid = 1'b0;
    reqLast  = 1'b0;
    expQ.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    #1;
    check(!rspAck && !rspRetry && !upReqValid, "R11 reset idle", int'(upReqValid), 0);
    rstN = 1'b1;
    idle(2);

    // R1 R4 R11: first miss with a stalled upstream accept
    stallReq = 3;
    f0 = fetchCount;
    readBurst(32'h0000_1000, 4);
    check(fetchCount - f0 == 1, "R4 one fetch for a miss", fetchCount - f0, 1);
    check(retries > 1, "R1 miss answered with retry", retries, 2);
    check(lastUpAddr == 32'h0000_1000, "R1 fetch address", int'(lastUpAddr), 32'h1000);
    check(lastUpWords == 16, "R2 prefetch length 4x16B", lastUpWords, 16);
    check(acks == 4 && stopSeen == 0, "R3 four words served", acks, 4);

    // R5: sequential short reads served from leftovers
    for (int k = 1; k < 4; k++) begin
      f0 = fetchCount;
      readBurst(32'h0000_1000 + 32'(16 * k), 4);
      check(retries == 0, "R5 no retry on hit", retries, 0);
      check(fetchCount == f0, "R5 no fetch on hit", fetchCount - f0, 0);
      check((stopSeen != 0) == (k == 3), "R10 stop on last word", stopSeen, int'(k == 3));
    end
    f0 = fetchCount;
    readBurst(32'h0000_1040, 2);
    check(fetchCount - f0 == 1, "R10 empty after drain", fetchCount - f0, 1);

    // R10: master wants more than was prefetched
    readBurst(32'h0000_2000, 20);
    check(acks == 16 && stopSeen == 1, "R10 stop after 16 words", acks, 16);

    // R7: non-sequential address refetches
    readBurst(32'h0000_3000, 4);
    f0 = fetchCount;
    readBurst(32'h0000_3200, 2);
    check(fetchCount - f0 == 1, "R7 jump refetches", fetchCount - f0, 1);
    f0 = fetchCount;
    readBurst(32'h0000_3010, 2);
    check(fetchCount - f0 == 1 && retries > 0, "R7 old window gone", fetchCount - f0, 1);

    // R6: cache disabled discards at disconnect
    cfgCacheEn = 1'b0;
    idle(30);
    readBurst(32'h0000_4000, 4);
    f0 = fetchCount;
    readBurst(32'h0000_4010, 4);
    check(fetchCount - f0 == 1 && retries > 0, "R6 refetch when disabled", fetchCount - f0, 1);
    cfgCacheEn = 1'b1;
    idle(30);

    // R8: expiry after the hold window
    cfgHold = 16'd20;
    readBurst(32'h0000_5000, 4);
    idle(60);
    f0 = fetchCount;
    readBurst(32'h0000_5010, 4);
    check(fetchCount - f0 == 1 && retries > 0, "R8 expired data refetched", fetchCount - f0, 1);

    // R8: hold of zero never expires
    cfgHold = 16'd0;
    idle(30);
    readBurst(32'h0000_6000, 4);
    idle(100);
    f0 = fetchCount;
    readBurst(32'h0000_6010, 4);
    check(fetchCount == f0 && retries == 0, "R8 zero hold keeps data", fetchCount - f0, 0);

    // R9: short hold, idle while the fetch is still streaming
    cfgHold = 16'd2;
    idle(30);
    readBurst(32'h0000_7000, 1);
    idle(3);
    f0 = fetchCount;
    readBurst(32'h0000_7004, 1);
    check(fetchCount == f0 && retries == 0, "R9 timer paused during fetch", fetchCount - f0, 0);
    idle(40);
    f0 = fetchCount;
    readBurst(32'h0000_7008, 1);
    check(fetchCount - f0 == 1, "R9 timer runs after fetch", fetchCount - f0, 1);

    // R2: other line sizes and the depth cap
    cfgHold = 16'd1000;
    idle(30);
    cfgLineSel = 2'd3; cfgLines = 4'd1;
    readBurst(32'h0000_8000, 40);
    check(acks == 32 && stopSeen == 1 && lastUpWords == 32, "R2 one 128B line", acks, 32);
    cfgLines = 4'd4;
    readBurst(32'h0000_9000, 70);
    check(acks == 64 && lastUpWords == 64, "R2 capped at depth", acks, 64);
    cfgLineSel = 2'd1; cfgLines = 4'd0;
    readBurst(32'h0000_A000, 10);
    check(acks == 8 && lastUpWords == 8, "R2 zero lines as one 32B line", acks, 8);

    idle(5);
    finishRun();
  end
endmodule